// File: doc/BRIEF.md
# Tag-Tracked Floating-Point Register File

This block holds the architectural floating-point registers of an out-of-order floating-point unit that issues in program order. Each register carries a data value, a pending flag and a small producer tag. The tag names the reservation station whose result the register is waiting for. The decode stage reads two source registers per cycle. Each read port returns either a ready value or, while the register is still pending, the tag a reservation station should wait on.

At issue, the decoder marks the destination register pending and writes the chosen station's identity into its tag. The block watches the shared result broadcast bus. Every pending register whose tag equals the broadcast tag takes the broadcast data and becomes ready. A result from an older producer no longer matches once the register has been reassigned, so it falls away on its own.

Register-to-register moves use no execution unit. If the source is still pending, only its tag is copied, so both registers later fill from the same broadcast. If the source is ready, its value is copied at once.

Top module: `fpTagRegFile`

## Requirements
- R1: Reset makes every register ready with the value zero.
- R2: An issue (issueValid high) to register issueDst makes that register pending with tag issueTag from the next cycle. A read of it then returns ready low and that tag.
- R3: A broadcast (busValid high) loads busData into every pending register whose tag equals busTag and makes each of them ready from the next cycle. Several registers may load from one broadcast.
- R4: A broadcast whose tag differs from a pending register's current tag leaves that register's pending state, tag and value unchanged.
- R5: A move whose source register is pending, and not matched by a broadcast in the same cycle, makes the destination pending with the source's tag. Both registers then load from the same later broadcast.
- R6: A move whose source register is ready copies the source value and leaves the destination ready.
- R7: When an issue and a matching broadcast hit the same register in the same cycle, the register ends pending with the new issue's tag.
- R8: A read of a pending register whose tag matches a broadcast in the same cycle returns ready high and busData in that cycle.
- R9: When issueValid and moveValid are both high in one cycle, only the issue takes effect and the move leaves its destination unchanged.
- R10: A move whose pending source matches a broadcast in the same cycle copies busData into the destination and leaves it ready.
- R11: A broadcast has no effect on a register that is ready, even when that register's stale tag equals busTag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | Issue a producer to issueDst this cycle |
| issueDst | input | 2 | Destination register of the issue |
| issueTag | input | 4 | Station identity written into the destination tag |
| moveValid | input | 1 | Register-to-register move this cycle |
| moveDst | input | 2 | Move destination register |
| moveSrc | input | 2 | Move source register |
| busValid | input | 1 | Result broadcast present |
| busTag | input | 4 | Producer tag of the broadcast |
| busData | input | 32 | Broadcast result value |
| srcAIdx | input | 2 | Register selected on read port A |
| srcBIdx | input | 2 | Register selected on read port B |
| srcAReady | output | 1 | Port A value is valid |
| srcATag | output | 4 | Port A tag to wait on when not ready |
| srcAValue | output | 32 | Port A value |
| srcBReady | output | 1 | Port B value is valid |
| srcBTag | output | 4 | Port B tag to wait on when not ready |
| srcBValue | output | 32 | Port B value |

## Verification
A wrong pending flag or tag shows on the very next read of that register. The port reports ready with a stale value where a tag was due, or it keeps reporting a tag that should already have resolved. A register that missed a broadcast stays pending forever. That is visible one cycle after the broadcast and at every later read, which is why each stimulus step reads a register back one cycle after its edge. Lost writes are caught the same way: a stale broadcast that wrongly lands, or a same-cycle issue that loses to a broadcast. Bypass errors only show in the cycle of the broadcast itself, so those reads are sampled before the edge.

// File: rtl/fpTagRegPkg.sv
package fpTagRegPkg;

  // Per-register write strobes produced by control, consumed by the datapath
  typedef struct packed {
    logic takeIssue;    // load new producer tag, become pending
    logic takeMoveTag;  // copy source tag, become pending
    logic takeMoveVal;  // copy source (or bypassed) value, become ready
    logic takeBus;      // load broadcast data, become ready
  } regStrobe_t;

  // Shared datapath steering for the move path
  typedef struct packed {
    logic moveFromBus;  // move source value comes from the broadcast
  } moveSteer_t;

endpackage

// File: rtl/fpTagRegCtl.sv
module fpTagRegCtl
  import fpTagRegPkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int TAG_W    = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                              issueValid,
  input  logic [IDX_W-1:0]                  issueDst,
  input  logic                              moveValid,
  input  logic [IDX_W-1:0]                  moveDst,
  input  logic [IDX_W-1:0]                  moveSrc,
  input  logic                              busValid,
  input  logic [TAG_W-1:0]                  busTag,
  input  logic [NUM_REGS-1:0]               busyVec,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]    tagArr,
  output logic [NUM_REGS-1:0]               hitVec,
  output regStrobe_t [NUM_REGS-1:0]         strobes,
  output moveSteer_t                        steer
);

  logic doIssue;
  logic doMove;
  logic srcStillPending;

  // A broadcast only counts for registers still waiting on that exact producer
  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      hitVec[i] = busValid && busyVec[i] && (tagArr[i] == busTag);
    end
  end

  // Issue and move share the single decode slot; issue has priority
  assign doIssue         = issueValid;
  assign doMove          = moveValid && !issueValid;
  assign srcStillPending = busyVec[moveSrc] && !hitVec[moveSrc];

  always_comb begin
    steer.moveFromBus = hitVec[moveSrc];
    for (int i = 0; i < NUM_REGS; i++) begin
      strobes[i].takeIssue   = doIssue && (issueDst == IDX_W'(i));
      strobes[i].takeMoveTag = doMove && (moveDst == IDX_W'(i)) && srcStillPending;
      strobes[i].takeMoveVal = doMove && (moveDst == IDX_W'(i)) && !srcStillPending;
      // Decode-side writes override a same-cycle broadcast to the same register
      strobes[i].takeBus     = hitVec[i]
                               && !strobes[i].takeIssue
                               && !strobes[i].takeMoveTag
                               && !strobes[i].takeMoveVal;
    end
  end

endmodule

// File: rtl/fpTagRegData.sv
module fpTagRegData
  import fpTagRegPkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 4,
  parameter int NUM_RD   = 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [TAG_W-1:0]                  issueTag,
  input  logic [IDX_W-1:0]                  moveSrc,
  input  logic [DATA_W-1:0]                 busData,
  input  regStrobe_t [NUM_REGS-1:0]         strobes,
  input  moveSteer_t                        steer,
  input  logic [NUM_REGS-1:0]               hitVec,
  input  logic [NUM_RD-1:0][IDX_W-1:0]      rdIdx,
  output logic [NUM_RD-1:0]                 rdReady,
  output logic [NUM_RD-1:0][TAG_W-1:0]      rdTag,
  output logic [NUM_RD-1:0][DATA_W-1:0]     rdValue,
  output logic [NUM_REGS-1:0]               busyVec,
  output logic [NUM_REGS-1:0][TAG_W-1:0]    tagArr,
  output logic [NUM_REGS-1:0][DATA_W-1:0]   valArr
);

  logic [DATA_W-1:0] moveVal;
  logic [TAG_W-1:0]  moveTag;

  assign moveVal = steer.moveFromBus ? busData : valArr[moveSrc];
  assign moveTag = tagArr[moveSrc];

  // Register storage: one slice per architectural register
  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        busyVec[g] <= 1'b0;
        tagArr[g]  <= '0;
        valArr[g]  <= '0;
      end else if (strobes[g].takeIssue) begin
        busyVec[g] <= 1'b1;
        tagArr[g]  <= issueTag;
      end else if (strobes[g].takeMoveTag) begin
        busyVec[g] <= 1'b1;
        tagArr[g]  <= moveTag;
      end else if (strobes[g].takeMoveVal) begin
        busyVec[g] <= 1'b0;
        valArr[g]  <= moveVal;
      end else if (strobes[g].takeBus) begin
        busyVec[g] <= 1'b0;
        valArr[g]  <= busData;
      end
    end
  end

  // Read ports with same-cycle broadcast bypass
  for (genvar p = 0; p < NUM_RD; p++) begin : gRd
    always_comb begin
      rdTag[p] = tagArr[rdIdx[p]];
      if (hitVec[rdIdx[p]]) begin
        rdReady[p] = 1'b1;
        rdValue[p] = busData;
      end else begin
        rdReady[p] = !busyVec[rdIdx[p]];
        rdValue[p] = valArr[rdIdx[p]];
      end
    end
  end

endmodule

// File: rtl/fpTagRegFile.sv
module fpTagRegFile
  import fpTagRegPkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [IDX_W-1:0]  issueDst,
  input  logic [TAG_W-1:0]  issueTag,
  input  logic              moveValid,
  input  logic [IDX_W-1:0]  moveDst,
  input  logic [IDX_W-1:0]  moveSrc,
  input  logic              busValid,
  input  logic [TAG_W-1:0]  busTag,
  input  logic [DATA_W-1:0] busData,
  input  logic [IDX_W-1:0]  srcAIdx,
  input  logic [IDX_W-1:0]  srcBIdx,
  output logic              srcAReady,
  output logic [TAG_W-1:0]  srcATag,
  output logic [DATA_W-1:0] srcAValue,
  output logic              srcBReady,
  output logic [TAG_W-1:0]  srcBTag,
  output logic [DATA_W-1:0] srcBValue
);

  localparam int NUM_RD = 2;

  logic [NUM_REGS-1:0]              busyVec;
  logic [NUM_REGS-1:0][TAG_W-1:0]   tagArr;
  logic [NUM_REGS-1:0][DATA_W-1:0]  valArr;
  logic [NUM_REGS-1:0]              hitVec;
  regStrobe_t [NUM_REGS-1:0]        strobes;
  moveSteer_t                       steer;
  logic [NUM_RD-1:0][IDX_W-1:0]     rdIdx;
  logic [NUM_RD-1:0]                rdReady;
  logic [NUM_RD-1:0][TAG_W-1:0]     rdTag;
  logic [NUM_RD-1:0][DATA_W-1:0]    rdValue;

  assign rdIdx[0]  = srcAIdx;
  assign rdIdx[1]  = srcBIdx;
  assign srcAReady = rdReady[0];
  assign srcATag   = rdTag[0];
  assign srcAValue = rdValue[0];
  assign srcBReady = rdReady[1];
  assign srcBTag   = rdTag[1];
  assign srcBValue = rdValue[1];

  fpTagRegCtl #(
    .NUM_REGS(NUM_REGS),
    .TAG_W   (TAG_W)
  ) uCtl (
    .issueValid(issueValid),
    .issueDst  (issueDst),
    .moveValid (moveValid),
    .moveDst   (moveDst),
    .moveSrc   (moveSrc),
    .busValid  (busValid),
    .busTag    (busTag),
    .busyVec   (busyVec),
    .tagArr    (tagArr),
    .hitVec    (hitVec),
    .strobes   (strobes),
    .steer     (steer)
  );

  fpTagRegData #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W),
    .TAG_W   (TAG_W),
    .NUM_RD  (NUM_RD)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .issueTag(issueTag),
    .moveSrc (moveSrc),
    .busData (busData),
    .strobes (strobes),
    .steer   (steer),
    .hitVec  (hitVec),
    .rdIdx   (rdIdx),
    .rdReady (rdReady),
    .rdTag   (rdTag),
    .rdValue (rdValue),
    .busyVec (busyVec),
    .tagArr  (tagArr),
    .valArr  (valArr)
  );

endmodule

// File: rtl/fpTagRegFileChecker.sv
module fpTagRegFileChecker #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             issueValid,
  input logic [IDX_W-1:0]                 issueDst,
  input logic [TAG_W-1:0]                 issueTag,
  input logic                             moveValid,
  input logic [IDX_W-1:0]                 moveDst,
  input logic [IDX_W-1:0]                 moveSrc,
  input logic                             busValid,
  input logic [TAG_W-1:0]                 busTag,
  input logic [DATA_W-1:0]                busData,
  input logic [IDX_W-1:0]                 srcAIdx,
  input logic                             srcAReady,
  input logic [DATA_W-1:0]                srcAValue,
  input logic [NUM_REGS-1:0]              busyVec,
  input logic [NUM_REGS-1:0][TAG_W-1:0]   tagArr,
  input logic [NUM_REGS-1:0][DATA_W-1:0]  valArr
);

  logic              aPend;
  logic [TAG_W-1:0]  aTag;
  logic              mSrcPend;
  logic [TAG_W-1:0]  mSrcTag;
  logic [DATA_W-1:0] mSrcVal;

  assign aPend    = busyVec[srcAIdx];
  assign aTag     = tagArr[srcAIdx];
  assign mSrcPend = busyVec[moveSrc];
  assign mSrcTag  = tagArr[moveSrc];
  assign mSrcVal  = valArr[moveSrc];

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rstN |=> (busyVec == '0 && valArr == '0)); // R1

  AST_READ_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && aPend && aTag == busTag) |-> (srcAReady && srcAValue == busData)); // R8

  for (genvar g = 0; g < NUM_REGS; g++) begin : gChk
    logic wrHere;
    assign wrHere = (issueValid && issueDst == IDX_W'(g)) || (moveValid && moveDst == IDX_W'(g));

    AST_ISSUE_MARKS: assert property (@(posedge clk) disable iff (!rstN)
      (issueValid && issueDst == IDX_W'(g)) |=> (busyVec[g] && tagArr[g] == $past(issueTag))); // R2

    AST_ISSUE_BEATS_BUS: assert property (@(posedge clk) disable iff (!rstN)
      (issueValid && issueDst == IDX_W'(g) && busValid && busyVec[g] && tagArr[g] == busTag)
      |=> busyVec[g]); // R7

    AST_BUS_LOADS: assert property (@(posedge clk) disable iff (!rstN)
      (busValid && busyVec[g] && tagArr[g] == busTag && !wrHere)
      |=> (!busyVec[g] && valArr[g] == $past(busData))); // R3

    AST_STALE_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
      (busValid && busyVec[g] && tagArr[g] != busTag && !wrHere)
      |=> (busyVec[g] && $stable(tagArr[g]) && $stable(valArr[g]))); // R4

    AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rstN)
      (!busyVec[g] && !wrHere) |=> (!busyVec[g] && $stable(valArr[g]))); // R11

    AST_MOVE_TAG: assert property (@(posedge clk) disable iff (!rstN)
      (moveValid && !issueValid && moveDst == IDX_W'(g) && mSrcPend
       && !(busValid && mSrcTag == busTag))
      |=> (busyVec[g] && tagArr[g] == $past(mSrcTag))); // R5

    AST_MOVE_VALUE: assert property (@(posedge clk) disable iff (!rstN)
      (moveValid && !issueValid && moveDst == IDX_W'(g) && !mSrcPend)
      |=> (!busyVec[g] && valArr[g] == $past(mSrcVal))); // R6
  end

endmodule

bind fpTagRegFile fpTagRegFileChecker #(
  .NUM_REGS(NUM_REGS),
  .DATA_W  (DATA_W),
  .TAG_W   (TAG_W)
) uChecker (
  .clk       (clk),
  .rstN      (rstN),
  .issueValid(issueValid),
  .issueDst  (issueDst),
  .issueTag  (issueTag),
  .moveValid (moveValid),
  .moveDst   (moveDst),
  .moveSrc   (moveSrc),
  .busValid  (busValid),
  .busTag    (busTag),
  .busData   (busData),
  .srcAIdx   (srcAIdx),
  .srcAReady (srcAReady),
  .srcAValue (srcAValue),
  .busyVec   (busyVec),
  .tagArr    (tagArr),
  .valArr    (valArr)
);

// File: tb/tb_fpTagRegFile.sv
`timescale 1ns/1ps
module tb_fpTagRegFile;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [1:0]  issueDst = '0;
  logic [3:0]  issueTag = '0;
  logic        moveValid = 1'b0;
  logic [1:0]  moveDst = '0;
  logic [1:0]  moveSrc = '0;
  logic        busValid = 1'b0;
  logic [3:0]  busTag = '0;
  logic [31:0] busData = '0;
  logic [1:0]  srcAIdx = '0;
  logic [1:0]  srcBIdx = '0;
  logic        srcAReady, srcBReady;
  logic [3:0]  srcATag, srcBTag;
  logic [31:0] srcAValue, srcBValue;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  fpTagRegFile dut (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueDst(issueDst), .issueTag(issueTag),
    .moveValid(moveValid), .moveDst(moveDst), .moveSrc(moveSrc),
    .busValid(busValid), .busTag(busTag), .busData(busData),
    .srcAIdx(srcAIdx), .srcBIdx(srcBIdx),
    .srcAReady(srcAReady), .srcATag(srcATag), .srcAValue(srcAValue),
    .srcBReady(srcBReady), .srcBTag(srcBTag), .srcBValue(srcBValue)
  );

  typedef struct packed {
    logic        iv; logic [1:0] idst; logic [3:0] itag;
    logic        mv; logic [1:0] mdst; logic [1:0] msrc;
    logic        bv; logic [3:0] btag; logic [31:0] bdata;
    logic [1:0]  chk; logic eRdy; logic [3:0] eTag; logic [31:0] eVal;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    // iv idst itag  mv mdst msrc  bv btag bdata        chk rdy tag val         req
    '{1'b1,2'd0,4'd10, 1'b0,2'd0,2'd0, 1'b0,4'd0, 32'h0,  2'd0,1'b0,4'd10,32'h0,  8'd2},  // R2
    '{1'b1,2'd1,4'd8,  1'b0,2'd0,2'd0, 1'b0,4'd0, 32'h0,  2'd1,1'b0,4'd8, 32'h0,  8'd2},  // R2
    '{1'b0,2'd0,4'd0,  1'b1,2'd2,2'd0, 1'b0,4'd0, 32'h0,  2'd2,1'b0,4'd10,32'h0,  8'd5},  // R5 tag copy
    '{1'b0,2'd0,4'd0,  1'b0,2'd0,2'd0, 1'b1,4'd10,32'h11, 2'd0,1'b1,4'd0, 32'h11, 8'd3},  // R3
    '{1'b0,2'd0,4'd0,  1'b0,2'd0,2'd0, 1'b0,4'd0, 32'h0,  2'd2,1'b1,4'd0, 32'h11, 8'd5},  // R5 shared fill
    '{1'b1,2'd0,4'd11, 1'b0,2'd0,2'd0, 1'b0,4'd0, 32'h0,  2'd0,1'b0,4'd11,32'h0,  8'd2},  // R2
    '{1'b1,2'd0,4'd12, 1'b0,2'd0,2'd0, 1'b0,4'd0, 32'h0,  2'd0,1'b0,4'd12,32'h0,  8'd2},  // R2 rewrite
    '{1'b0,2'd0,4'd0,  1'b0,2'd0,2'd0, 1'b1,4'd11,32'h22, 2'd0,1'b0,4'd12,32'h0,  8'd4},  // R4 stale
    '{1'b0,2'd0,4'd0,  1'b1,2'd3,2'd2, 1'b0,4'd0, 32'h0,  2'd3,1'b1,4'd0, 32'h11, 8'd6},  // R6
    '{1'b1,2'd0,4'd9,  1'b0,2'd0,2'd0, 1'b1,4'd12,32'h33, 2'd0,1'b0,4'd9, 32'h0,  8'd7},  // R7
    '{1'b0,2'd0,4'd0,  1'b0,2'd0,2'd0, 1'b1,4'd8, 32'h44, 2'd1,1'b1,4'd0, 32'h44, 8'd3},  // R3
    '{1'b1,2'd3,4'd5,  1'b1,2'd2,2'd1, 1'b0,4'd0, 32'h0,  2'd3,1'b0,4'd5, 32'h0,  8'd9},  // R9 issue taken
    '{1'b0,2'd0,4'd0,  1'b0,2'd0,2'd0, 1'b0,4'd0, 32'h0,  2'd2,1'b1,4'd0, 32'h11, 8'd9},  // R9 move dropped
    '{1'b0,2'd0,4'd0,  1'b1,2'd2,2'd3, 1'b1,4'd5, 32'h55, 2'd2,1'b1,4'd0, 32'h55, 8'd10}, // R10
    '{1'b0,2'd0,4'd0,  1'b0,2'd0,2'd0, 1'b0,4'd0, 32'h0,  2'd3,1'b1,4'd0, 32'h55, 8'd3},  // R3
    '{1'b0,2'd0,4'd0,  1'b0,2'd0,2'd0, 1'b1,4'd9, 32'h66, 2'd0,1'b1,4'd0, 32'h66, 8'd3},  // R3
    '{1'b0,2'd0,4'd0,  1'b0,2'd0,2'd0, 1'b1,4'd9, 32'h77, 2'd0,1'b1,4'd0, 32'h66, 8'd11}  // R11
  };

  task automatic expectA(string req, logic eRdy, logic [3:0] eTag, logic [31:0] eVal);
    checks++;
    if (srcAReady !== eRdy || (eRdy && srcAValue !== eVal) || (!eRdy && srcATag !== eTag)) begin
      failures++;
      $display("FAIL %s portA: got rdy=%0b tag=%0d val=%h expected rdy=%0b tag=%0d val=%h",
               req, srcAReady, srcATag, srcAValue, eRdy, eTag, eVal);
    end
  endtask

  task automatic expectB(string req, logic eRdy, logic [3:0] eTag, logic [31:0] eVal);
    checks++;
    if (srcBReady !== eRdy || (eRdy && srcBValue !== eVal) || (!eRdy && srcBTag !== eTag)) begin
      failures++;
      $display("FAIL %s portB: got rdy=%0b tag=%0d val=%h expected rdy=%0b tag=%0d val=%h",
               req, srcBReady, srcBTag, srcBValue, eRdy, eTag, eVal);
    end
  endtask

  task automatic clearOps();
    issueValid = 1'b0; moveValid = 1'b0; busValid = 1'b0;
  endtask

  task automatic checkAllZero(string req);
    for (int r = 0; r < 4; r++) begin
      srcAIdx = 2'(r); srcBIdx = 2'(3 - r);
      #1;
      expectA(req, 1'b1, 4'd0, 32'h0);
      expectB(req, 1'b1, 4'd0, 32'h0);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checkAllZero("R1");                // R1 reset state
    @(negedge clk);
    rstN = 1'b1;

    // Vector walk: drive one cycle, read back one register after the edge
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      issueValid = VECS[v].iv; issueDst = VECS[v].idst; issueTag = VECS[v].itag;
      moveValid  = VECS[v].mv; moveDst  = VECS[v].mdst; moveSrc  = VECS[v].msrc;
      busValid   = VECS[v].bv; busTag   = VECS[v].btag; busData  = VECS[v].bdata;
      @(posedge clk);
      #2;
      clearOps();
      srcAIdx = VECS[v].chk;
      #2;
      expectA($sformatf("R%0d vec%0d", VECS[v].req, v), VECS[v].eRdy, VECS[v].eTag, VECS[v].eVal);
    end

    // R8: same-cycle bypass on a read port
    @(negedge clk);
    issueValid = 1'b1; issueDst = 2'd1; issueTag = 4'd3;
    @(posedge clk); #2; clearOps();
    srcBIdx = 2'd1; #1;
    expectB("R8 pending before bus", 1'b0, 4'd3, 32'h0);
    @(negedge clk);
    busValid = 1'b1; busTag = 4'd3; busData = 32'hAB;
    srcAIdx = 2'd1; srcBIdx = 2'd0;
    #1;
    expectA("R8 bypass", 1'b1, 4'd0, 32'hAB);
    expectB("R8 unrelated reg", 1'b1, 4'd0, 32'h66);
    @(posedge clk); #2; clearOps(); #1;
    expectA("R3 after bypass", 1'b1, 4'd0, 32'hAB);

    // R4 again via two registers awaiting distinct producers
    @(negedge clk);
    issueValid = 1'b1; issueDst = 2'd2; issueTag = 4'd14;
    @(posedge clk); #2; clearOps();
    @(negedge clk);
    busValid = 1'b1; busTag = 4'd13; busData = 32'hDEAD;
    @(posedge clk); #2; clearOps();
    srcAIdx = 2'd2; #1;
    expectA("R4 other tag", 1'b0, 4'd14, 32'h0);

    // R1: reset in mid-run clears pending state and values
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk); #2;
    checkAllZero("R1 mid-run");
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #2;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule